// File: doc/BRIEF.md
# Function-Tagged PIO Bridge

This block sits between a request decoder and a user register space. Each request that arrives from the host side has already been decoded. It carries a base address register number, the physical and virtual function numbers, a flag saying whether it comes from a virtual function, a byte address, a read or write type, a 64-bit write payload and a tag. Only hits on register window number two are passed on. The block accepts such a hit and checks that it is aligned to a 64-bit word and that it falls inside the window. It then issues exactly one non-burst 64-bit access on a memory-mapped master port that has a waitrequest handshake.

The master address gives every function its own register window. From the top bit down, the address is the virtual-function flag, then the physical function number, then the virtual function number, then the offset inside the window. The function fields are as wide as the function counts need. A field whose count is one keeps a single bit, so no field ever has zero width.

Read data comes back with the tag of the request that caused it. Only one access is outstanding at a time. A request that fails alignment or range checking is never issued. Its tag is reported on a one-cycle error pulse instead, and for a read no data is returned.

Top module: `fn_pio_bridge`

## Requirements
- R1: A request is forwarded only when its window code `req_bar` equals 2. For any other code the request is still taken (`req_ready` high) but it produces no master access, no error pulse and no read response, whatever its address.
- R2: For a forwarded request, `m_address` equals {`req_vf_active`, `req_pf`, VF field, `req_addr[BAR_LOG2-1:0]`}, listed from the most significant bit down. The VF field is `req_vf` when `req_vf_active` is 1 and zero when it is 0.
- R3: A window-2 request with `req_addr[2:0]` not zero is not issued. `err_valid` pulses for one cycle, in the cycle after the request is taken, with `err_tag` equal to its tag. No read response follows.
- R4: A window-2 request with any bit of `req_addr` at or above bit `BAR_LOG2` set is treated the same way as in R3: no access, one error pulse carrying its tag, no read response.
- R5: Every access asserts exactly one of `m_read` and `m_write` and drives `m_byteenable` as 8'hFF. A write drives `m_writedata` equal to `req_wdata`. The command drops in the cycle after it is accepted (`m_waitrequest` low), so each request gives exactly one beat.
- R6: While `m_waitrequest` is high during an access, `m_address`, `m_read`, `m_write` and `m_writedata` hold their values.
- R7: `req_ready` is high only when no access is pending. It returns high in the cycle after a write is accepted, and in the cycle after the `m_readdatavalid` beat of a read.
- R8: For a read, `rsp_valid` pulses for one cycle, in the cycle after `m_readdatavalid`. It carries `rsp_data` equal to `m_readdata` and `rsp_tag` equal to the request tag.
- R9: An `m_readdatavalid` beat that arrives while no read is waiting for data has no effect. No response is produced, and the following read returns its own data.
- R10: While reset is held, `req_ready` is 1 and `m_read`, `m_write`, `rsp_valid` and `err_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_bar | input | 3 | Base address register number of the hit |
| req_pf | input | PF_W | Physical function number |
| req_vf | input | VF_W | Virtual function number |
| req_vf_active | input | 1 | Request comes from a virtual function |
| req_addr | input | REQ_ADDR_W | Byte address within the window |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 64 | Write payload |
| req_tag | input | TAG_W | Request tag |
| m_address | output | MA_W | Function-tagged master address |
| m_read | output | 1 | Master read command |
| m_write | output | 1 | Master write command |
| m_writedata | output | 64 | Master write data |
| m_byteenable | output | 8 | Byte enables, always all ones |
| m_waitrequest | input | 1 | Slave stalls the command |
| m_readdata | input | 64 | Read data from slave |
| m_readdatavalid | input | 1 | Read data beat valid |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | 64 | Read response data |
| rsp_tag | output | TAG_W | Tag of the read being answered |
| err_valid | output | 1 | Rejected request pulse |
| err_tag | output | TAG_W | Tag of the rejected request |

## Verification
A read response and the acceptance of the next request fall in the same cycle. `rsp_valid` is raised in the cycle in which `req_ready` comes back. The bench provokes this by presenting each new request in exactly that cycle, throughout a sweep over every function number, flag value and aligned offset of a small configuration. In that shared cycle it judges the returned data and tag against the values it supplied. On the following cycle it judges the new command's computed address, and checks that the response pulse has gone away.

// File: rtl/fn_pio_pkg.sv
package fn_pio_pkg;

   localparam int DATA_W    = 64;
   localparam int BE_W      = DATA_W / 8;
   localparam int ALIGN_W   = $clog2(BE_W);
   localparam int BAR_SEL_W = 3;
   localparam logic [BAR_SEL_W-1:0] PIO_BAR = 3'd2;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CMD    = 2'd1,
      ST_RDWAIT = 2'd2
   } pio_state_e;

   function automatic int fld_w(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/fn_pio_decode.sv
module fn_pio_decode
   import fn_pio_pkg::*;
#(
   parameter int PF_W       = 2,
   parameter int VF_W       = 3,
   parameter int BAR_LOG2   = 22,
   parameter int REQ_ADDR_W = 32,
   localparam int MA_W      = 1 + PF_W + VF_W + BAR_LOG2
)(
   input  logic [BAR_SEL_W-1:0]  bar,
   input  logic [PF_W-1:0]       pf,
   input  logic [VF_W-1:0]       vf,
   input  logic                  vf_active,
   input  logic [REQ_ADDR_W-1:0] addr,
   output logic                  hit,
   output logic                  bad,
   output logic [MA_W-1:0]       tagged_addr
);

   logic misaligned;
   logic out_of_range;
   logic [VF_W-1:0] vf_field;

   assign hit        = (bar == PIO_BAR);
   assign misaligned = |addr[ALIGN_W-1:0];

   generate
      if (REQ_ADDR_W > BAR_LOG2) begin : g_range
         assign out_of_range = |addr[REQ_ADDR_W-1:BAR_LOG2];
      end else begin : g_norange
         assign out_of_range = 1'b0;
      end
   endgenerate

   assign bad      = misaligned | out_of_range;
   assign vf_field = vf_active ? vf : '0;

   assign tagged_addr = {vf_active, pf, vf_field, addr[BAR_LOG2-1:0]};

endmodule

// File: rtl/fn_pio_ctrl.sv
module fn_pio_ctrl
   import fn_pio_pkg::*;
#(
   parameter int MA_W  = 28,
   parameter int TAG_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              hit,
   input  logic              bad,
   input  logic [MA_W-1:0]   tagged_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   output logic [MA_W-1:0]   m_address,
   output logic              m_read,
   output logic              m_write,
   output logic [DATA_W-1:0] m_writedata,
   input  logic              m_waitrequest,
   input  logic              m_readdatavalid,
   output logic              rd_done,
   output logic [TAG_W-1:0]  rd_tag,
   output logic              err_evt,
   output logic [TAG_W-1:0]  err_evt_tag
);

   pio_state_e state_q;
   logic              cmd_wr_q;
   logic [MA_W-1:0]   addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [TAG_W-1:0]  tag_q;
   logic              accept;
   logic              launch;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign launch    = accept && hit && !bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cmd_wr_q <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
         tag_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (launch) begin
                  state_q  <= ST_CMD;
                  cmd_wr_q <= req_write;
                  addr_q   <= tagged_addr;
                  wdata_q  <= req_wdata;
                  tag_q    <= req_tag;
               end
            end
            ST_CMD: begin
               if (!m_waitrequest) begin
                  state_q <= cmd_wr_q ? ST_IDLE : ST_RDWAIT;
               end
            end
            ST_RDWAIT: begin
               if (m_readdatavalid) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign m_address   = addr_q;
   assign m_writedata = wdata_q;
   assign m_read      = (state_q == ST_CMD) && !cmd_wr_q;
   assign m_write     = (state_q == ST_CMD) &&  cmd_wr_q;

   assign rd_done     = (state_q == ST_RDWAIT) && m_readdatavalid;
   assign rd_tag      = tag_q;
   assign err_evt     = accept && hit && bad;
   assign err_evt_tag = req_tag;

   // R6: stalled command is held
   a_r6_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read || m_write) && m_waitrequest |=>
         $stable(m_address) && $stable(m_read) && $stable(m_write) && $stable(m_writedata));

   // R5: never both commands
   a_r5_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m_read, m_write}));

   // R5: accepted command drops next cycle
   a_r5_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read || m_write) && !m_waitrequest |=> !m_read && !m_write);

   // R7: ready returns after accepted write
   a_r7_ready_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      m_write && !m_waitrequest |=> req_ready);

   // R7: no new request taken while a command is on the bus
   a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read || m_write) |-> !req_ready);

endmodule

// File: rtl/fn_pio_resp.sv
module fn_pio_resp
   import fn_pio_pkg::*;
#(
   parameter int TAG_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_done,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic [DATA_W-1:0] m_readdata,
   input  logic              err_evt,
   input  logic [TAG_W-1:0]  err_evt_tag,
   input  logic              m_readdatavalid,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic              err_valid,
   output logic [TAG_W-1:0]  err_tag
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_tag   <= '0;
         err_valid <= 1'b0;
         err_tag   <= '0;
      end else begin
         rsp_valid <= rd_done;
         err_valid <= err_evt;
         if (rd_done) begin
            rsp_data <= m_readdata;
            rsp_tag  <= rd_tag;
         end
         if (err_evt) begin
            err_tag <= err_evt_tag;
         end
      end
   end

   // R8: a response follows a data beat
   a_r8_rsp_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(m_readdatavalid));

   // R3: rejected request never produces a response alongside the error
   a_r3_err_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> !rsp_valid);

endmodule

// File: rtl/fn_pio_bridge.sv
module fn_pio_bridge
   import fn_pio_pkg::*;
#(
   parameter int NUM_PF     = 4,
   parameter int NUM_VF     = 8,
   parameter int BAR_LOG2   = 22,
   parameter int REQ_ADDR_W = 32,
   parameter int TAG_W      = 8,
   localparam int PF_W      = fld_w(NUM_PF),
   localparam int VF_W      = fld_w(NUM_VF),
   localparam int MA_W      = 1 + PF_W + VF_W + BAR_LOG2
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [BAR_SEL_W-1:0]  req_bar,
   input  logic [PF_W-1:0]       req_pf,
   input  logic [VF_W-1:0]       req_vf,
   input  logic                  req_vf_active,
   input  logic [REQ_ADDR_W-1:0] req_addr,
   input  logic                  req_write,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [TAG_W-1:0]      req_tag,
   output logic [MA_W-1:0]       m_address,
   output logic                  m_read,
   output logic                  m_write,
   output logic [DATA_W-1:0]     m_writedata,
   output logic [BE_W-1:0]       m_byteenable,
   input  logic                  m_waitrequest,
   input  logic [DATA_W-1:0]     m_readdata,
   input  logic                  m_readdatavalid,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_data,
   output logic [TAG_W-1:0]      rsp_tag,
   output logic                  err_valid,
   output logic [TAG_W-1:0]      err_tag
);

   generate
      if (NUM_PF < 1) begin : g_chk_pf
         $error("NUM_PF must be at least 1");
      end
      if (NUM_VF < 1) begin : g_chk_vf
         $error("NUM_VF must be at least 1");
      end
      if (BAR_LOG2 < ALIGN_W) begin : g_chk_bar
         $error("BAR_LOG2 must cover one 64-bit word");
      end
      if (REQ_ADDR_W < BAR_LOG2) begin : g_chk_aw
         $error("REQ_ADDR_W must be at least BAR_LOG2");
      end
      if (TAG_W < 1) begin : g_chk_tag
         $error("TAG_W must be at least 1");
      end
   endgenerate

   logic            dec_hit;
   logic            dec_bad;
   logic [MA_W-1:0] dec_addr;
   logic            rd_done;
   logic [TAG_W-1:0] rd_tag;
   logic            err_evt;
   logic [TAG_W-1:0] err_evt_tag;

   fn_pio_decode #(
      .PF_W       (PF_W),
      .VF_W       (VF_W),
      .BAR_LOG2   (BAR_LOG2),
      .REQ_ADDR_W (REQ_ADDR_W)
   ) u_decode (
      .bar         (req_bar),
      .pf          (req_pf),
      .vf          (req_vf),
      .vf_active   (req_vf_active),
      .addr        (req_addr),
      .hit         (dec_hit),
      .bad         (dec_bad),
      .tagged_addr (dec_addr)
   );

   fn_pio_ctrl #(
      .MA_W  (MA_W),
      .TAG_W (TAG_W)
   ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid       (req_valid),
      .req_ready       (req_ready),
      .hit             (dec_hit),
      .bad             (dec_bad),
      .tagged_addr     (dec_addr),
      .req_write       (req_write),
      .req_wdata       (req_wdata),
      .req_tag         (req_tag),
      .m_address       (m_address),
      .m_read          (m_read),
      .m_write         (m_write),
      .m_writedata     (m_writedata),
      .m_waitrequest   (m_waitrequest),
      .m_readdatavalid (m_readdatavalid),
      .rd_done         (rd_done),
      .rd_tag          (rd_tag),
      .err_evt         (err_evt),
      .err_evt_tag     (err_evt_tag)
   );

   fn_pio_resp #(
      .TAG_W (TAG_W)
   ) u_resp (
      .clk             (clk),
      .rst_n           (rst_n),
      .rd_done         (rd_done),
      .rd_tag          (rd_tag),
      .m_readdata      (m_readdata),
      .err_evt         (err_evt),
      .err_evt_tag     (err_evt_tag),
      .m_readdatavalid (m_readdatavalid),
      .rsp_valid       (rsp_valid),
      .rsp_data        (rsp_data),
      .rsp_tag         (rsp_tag),
      .err_valid       (err_valid),
      .err_tag         (err_tag)
   );

   assign m_byteenable = '1;

   // R3: issued addresses are always word aligned
   a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read || m_write) |-> (m_address[ALIGN_W-1:0] == '0));

   // R1: a non-window request never starts a command
   a_r1_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && (req_bar != PIO_BAR) |=> !m_read && !m_write && !err_valid);

endmodule

// File: tb/fn_pio_bridge_tb.sv
module fn_pio_bridge_tb;

   localparam int NPF = 2;
   localparam int NVF = 4;
   localparam int BL  = 6;
   localparam int AW  = 8;
   localparam int TW  = 4;
   localparam int PFW = 1;
   localparam int VFW = 2;
   localparam int MAW = 1 + PFW + VFW + BL;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           rst_n;
   logic           req_valid;
   logic           req_ready;
   logic [2:0]     req_bar;
   logic [PFW-1:0] req_pf;
   logic [VFW-1:0] req_vf;
   logic           req_vf_active;
   logic [AW-1:0]  req_addr;
   logic           req_write;
   logic [63:0]    req_wdata;
   logic [TW-1:0]  req_tag;
   logic [MAW-1:0] m_address;
   logic           m_read;
   logic           m_write;
   logic [63:0]    m_writedata;
   logic [7:0]     m_byteenable;
   logic           m_waitrequest;
   logic [63:0]    m_readdata;
   logic           m_readdatavalid;
   logic           rsp_valid;
   logic [63:0]    rsp_data;
   logic [TW-1:0]  rsp_tag;
   logic           err_valid;
   logic [TW-1:0]  err_tag;

   fn_pio_bridge #(
      .NUM_PF(NPF), .NUM_VF(NVF), .BAR_LOG2(BL), .REQ_ADDR_W(AW), .TAG_W(TW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_bar(req_bar), .req_pf(req_pf), .req_vf(req_vf),
      .req_vf_active(req_vf_active), .req_addr(req_addr), .req_write(req_write),
      .req_wdata(req_wdata), .req_tag(req_tag), .m_address(m_address),
      .m_read(m_read), .m_write(m_write), .m_writedata(m_writedata),
      .m_byteenable(m_byteenable), .m_waitrequest(m_waitrequest),
      .m_readdata(m_readdata), .m_readdatavalid(m_readdatavalid),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
      .err_valid(err_valid), .err_tag(err_tag)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [MAW-1:0] exp_addr(input int pf, input int vf,
                                                input int vfa, input int addr);
      int v;
      v = vfa * (1 << (PFW + VFW + BL)) + pf * (1 << (VFW + BL))
        + (vfa != 0 ? vf : 0) * (1 << BL) + (addr % (1 << BL));
      return MAW'(v);
   endfunction

   task automatic drive_req(input int bar, input int pf, input int vf, input int vfa,
                            input int addr, input bit wr, input logic [63:0] data,
                            input int tag);
      chk(req_ready === 1'b1, "R7 ready before request", 64'(req_ready), 64'd1);
      req_valid     = 1'b1;
      req_bar       = 3'(bar);
      req_pf        = PFW'(pf);
      req_vf        = VFW'(vf);
      req_vf_active = vfa[0];
      req_addr      = AW'(addr);
      req_write     = wr;
      req_wdata     = data;
      req_tag       = TW'(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_good(input int pf, input int vf, input int vfa, input int addr,
                          input bit wr, input logic [63:0] data, input int tag,
                          input int w, input int lat, input bit stray);
      logic [MAW-1:0] ea;
      ea = exp_addr(pf, vf, vfa, addr);
      drive_req(2, pf, vf, vfa, addr, wr, data, tag);
      chk(m_address === ea, "R2 tagged address", 64'(m_address), 64'(ea));
      chk(m_read === !wr && m_write === wr, "R5 command type",
          {62'd0, m_read, m_write}, {62'd0, !wr, wr});
      chk(m_byteenable === 8'hFF, "R5 byte enable", 64'(m_byteenable), 64'hFF);
      if (wr) chk(m_writedata === data, "R5 write data", m_writedata, data);
      chk(req_ready === 1'b0, "R7 busy", 64'(req_ready), 64'd0);
      chk(rsp_valid === 1'b0 && err_valid === 1'b0, "R8 no stray pulses",
          {62'd0, rsp_valid, err_valid}, 64'd0);
      for (int i = 0; i < w; i++) begin
         if (stray) m_readdatavalid = 1'b1;
         m_readdata = 64'hDEAD_0000_0000_BEEF;
         @(negedge clk);
         m_readdatavalid = 1'b0;
         chk(m_address === ea && m_read === !wr && m_write === wr &&
             (!wr || m_writedata === data), "R6 held under stall",
             64'(m_address), 64'(ea));
         chk(rsp_valid === 1'b0, "R9 beat during stall ignored", 64'(rsp_valid), 64'd0);
      end
      m_waitrequest = 1'b0;
      @(negedge clk);
      m_waitrequest = 1'b1;
      chk(m_read === 1'b0 && m_write === 1'b0, "R5 single beat",
          {62'd0, m_read, m_write}, 64'd0);
      if (wr) begin
         chk(req_ready === 1'b1, "R7 ready after write", 64'(req_ready), 64'd1);
      end else begin
         chk(req_ready === 1'b0, "R7 waiting for read data", 64'(req_ready), 64'd0);
         for (int i = 0; i < lat; i++) @(negedge clk);
         m_readdatavalid = 1'b1;
         m_readdata      = data;
         @(negedge clk);
         m_readdatavalid = 1'b0;
         chk(rsp_valid === 1'b1, "R8 response pulse", 64'(rsp_valid), 64'd1);
         chk(rsp_data === data, "R8 response data", rsp_data, data);
         chk(rsp_tag === TW'(tag), "R8 response tag", 64'(rsp_tag), 64'(tag));
         chk(req_ready === 1'b1, "R7 ready after read beat", 64'(req_ready), 64'd1);
      end
   endtask

   task automatic do_bad(input int bar, input int addr, input bit wr, input int tag,
                         input bit expect_err, input string req);
      drive_req(bar, 1, 3, 1, addr, wr, 64'h1234, tag);
      chk(m_read === 1'b0 && m_write === 1'b0, {req, " no access"},
          {62'd0, m_read, m_write}, 64'd0);
      chk(err_valid === expect_err, {req, " error pulse"}, 64'(err_valid), 64'(expect_err));
      if (expect_err) chk(err_tag === TW'(tag), {req, " error tag"}, 64'(err_tag), 64'(tag));
      chk(rsp_valid === 1'b0, {req, " no response"}, 64'(rsp_valid), 64'd0);
      chk(req_ready === 1'b1, {req, " still ready"}, 64'(req_ready), 64'd1);
      @(negedge clk);
      chk(err_valid === 1'b0 && rsp_valid === 1'b0 && !m_read && !m_write,
          {req, " pulse ends"}, {62'd0, err_valid, rsp_valid}, 64'd0);
   endtask

   initial begin
      #(20ns * 200000);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      rst_n = 1'b0; req_valid = 1'b0; req_bar = '0; req_pf = '0; req_vf = '0;
      req_vf_active = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
      req_tag = '0; m_waitrequest = 1'b1; m_readdata = '0; m_readdatavalid = 1'b0;
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1 && m_read === 1'b0 && m_write === 1'b0 &&
          rsp_valid === 1'b0 && err_valid === 1'b0, "R10 reset state",
          {59'd0, req_ready, m_read, m_write, rsp_valid, err_valid}, 64'h10);
      rst_n = 1'b1;
      @(negedge clk);

      n = 0;
      for (int vfa = 0; vfa < 2; vfa++)
         for (int pf = 0; pf < NPF; pf++)
            for (int vf = 0; vf < NVF; vf++)
               for (int off = 0; off < (1 << BL); off += 8) begin
                  logic [63:0] d;
                  d = {32'(n * 32'h9E37_79B9), 32'(off + (pf << 8) + (vf << 12) + (vfa << 16))};
                  do_good(pf, vf, vfa, off, 1'b1, d, n, n % 3, 0, 1'b0);
                  do_good(pf, vf, vfa, off, 1'b0, ~d, n + 1, (n + 1) % 3, n % 3,
                          (n % 2) == 0);
                  n += 2;
               end

      for (int b = 0; b < 8; b++)
         if (b != 2) begin
            do_bad(b, 8'h08, b[0], b, 1'b0, "R1 other window");
            do_bad(b, 8'hC3, 1'b0, b + 8, 1'b0, "R1 other window bad addr");
         end

      for (int k = 1; k < 8; k++) begin
         do_bad(2, 8'h10 + k, k[0], k, 1'b1, "R3 misaligned");
      end
      do_bad(2, 8'h3F, 1'b0, 5, 1'b1, "R3 misaligned top");

      do_bad(2, 8'h40, 1'b0, 9,  1'b1, "R4 out of range");
      do_bad(2, 8'h80, 1'b1, 10, 1'b1, "R4 out of range");
      do_bad(2, 8'hC8, 1'b0, 11, 1'b1, "R4 out of range");
      do_bad(2, 8'hF8, 1'b1, 12, 1'b1, "R4 out of range");
      do_bad(2, 8'h41, 1'b0, 13, 1'b1, "R4 out of range and misaligned");

      m_readdatavalid = 1'b1;
      m_readdata      = 64'hFFFF_0000_FFFF_0000;
      @(negedge clk);
      m_readdatavalid = 1'b0;
      chk(rsp_valid === 1'b0, "R9 idle beat ignored", 64'(rsp_valid), 64'd0);
      chk(req_ready === 1'b1, "R9 idle beat keeps ready", 64'(req_ready), 64'd1);
      do_good(1, 2, 1, 8'h38, 1'b0, 64'h0123_4567_89AB_CDEF, 7, 1, 1, 1'b1);
      do_good(0, 3, 0, 8'h00, 1'b0, 64'hA5A5_5A5A_0F0F_F0F0, 3, 0, 0, 1'b0);
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R8 pulse is one cycle", 64'(rsp_valid), 64'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule